// File: doc/BRIEF.md
# Two-Stage Configuration Register Bank

This block holds a set of configuration words for the logic around it. Each word exists twice: a staging copy that the host writes, and an active copy whose value is presented on a flat output bus to the logic being configured. A small control register chooses between two write modes. In pass-through mode a host write lands in both copies at once. In staged mode it lands only in the staging copy, and a later commit request copies every staging word into its active word on one clock edge.

After reset the bank waits for a supply-good input. It then reads a stored image from a nonvolatile memory, one word per cycle, into the staging copies. When the last word is in, it commits the whole image to the active copies. A busy output stays high from reset until that commit, so a bus front end can refuse every access. The host can request the same load sequence again to restore the stored image. The running configuration does not change until the final commit of that load. The control register also carries an enable bit that either passes page-erase requests to the nonvolatile store or drops them.

Top module: `cfg_dbuf_bank`

## Requirements
- R1: While reset is asserted, every active word reads 0, the control readback `ctl_q` reads 0 and `busy` reads 1.
- R2: With control bit 0 (pass-through) set, a host write of data D to address A makes active word A equal D at the next clock edge.
- R3: With control bit 0 clear, a host write leaves every active word unchanged.
- R4: A control write with bit 1 set copies all staging words into the active words on that clock edge. Bit 1 is not stored. `ctl_q` bit 0 reads back the pass-through bit and `ctl_q` bit 1 reads back the erase-enable bit (control bit 2).
- R5: When a host write and a commit request occur in the same cycle, the commit uses the staging values from before the write. In pass-through mode the written word's active copy takes the new data.
- R6: After reset, no nonvolatile read starts and `busy` stays 1 for as long as `supply_ok` is 0.
- R7: The load asserts `nv_rd_en` for N consecutive cycles with `nv_addr` going 0, 1, … N-1, starting the cycle after `supply_ok` is sampled high. The memory returns data one cycle after each read. `busy` falls N+2 cycles after the start edge, and at that edge every active word equals the image.
- R8: While `busy` is 1, host writes and control writes have no effect.
- R9: A control write with bit 3 set raises `busy` at the next edge and runs the same load again. The active words keep their previous values until the final commit and then equal the stored image.
- R10: `nv_erase` equals `erase_req` in the same cycle when the erase-enable bit is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply has passed its lockout level; permits the power-up load |
| wr_en | input | 1 | Host write strobe for a configuration word |
| wr_addr | input | AW | Host write address |
| wr_data | input | W | Host write data |
| ctl_wr | input | 1 | Host write strobe for the control register |
| ctl_din | input | 4 | Control data: 0 pass-through, 1 commit, 2 erase enable, 3 reload |
| erase_req | input | 1 | Page-erase request from the host side |
| nv_data | input | W | Nonvolatile read data, valid one cycle after a read |
| nv_rd_en | output | 1 | Nonvolatile read enable |
| nv_addr | output | AW | Nonvolatile read address |
| nv_erase | output | 1 | Gated page-erase request to the store |
| busy | output | 1 | Load in progress; accesses must be refused |
| ctl_q | output | 2 | Control readback {erase enable, pass-through} |
| act_cfg | output | N*W | Active configuration words, word i at bits [i*W +: W] |

## Verification
Host and control writes show their effect on `act_cfg` and `ctl_q` one edge after the cycle in which they are presented. `nv_erase` follows `erase_req` within the same cycle. During a load, `nv_addr` advances once per cycle beginning one cycle after the start edge, and `busy` with the committed image appears N+2 edges after it. The bench drives inputs just after each rising edge. A behavioural model advances on the same rising edge and keeps a countdown instead of a read pipeline. All outputs are compared with the model at every falling edge, so each result is sampled in the cycle where it is due, with no slack allowed.

// File: rtl/cfg_dbuf_bank.sv
module cfg_dbuf_bank #(
  parameter int NREG = 16,
  parameter int W    = 8,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_din,
  input  logic              erase_req,
  input  logic [W-1:0]      nv_data,
  output logic              nv_rd_en,
  output logic [AW-1:0]     nv_addr,
  output logic              nv_erase,
  output logic              busy,
  output logic [1:0]        ctl_q,
  output logic [NREG*W-1:0] act_cfg
);

  logic [W-1:0]      stage  [NREG];
  logic [W-1:0]      active [NREG];
  logic [NREG*W-1:0] stage_flat;
  logic              xparent, erase_en, busy_q, loading, fill_v, done_pend;
  logic [AW:0]       iss_ptr;
  logic [AW-1:0]     fill_ptr;

  wire host_ok    = !busy_q;
  wire commit_req = host_ok && ctl_wr && ctl_din[1];
  wire reload     = host_ok && ctl_wr && ctl_din[3];
  wire do_commit  = commit_req || done_pend;
  wire addr_ok    = 32'(wr_addr) < NREG;

  assign nv_rd_en = loading && (iss_ptr < (AW+1)'(NREG));
  assign nv_addr  = iss_ptr[AW-1:0];
  assign nv_erase = erase_req & erase_en;
  assign busy     = busy_q;
  assign ctl_q    = {erase_en, xparent};

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign act_cfg[g*W +: W]    = active[g];
    assign stage_flat[g*W +: W] = stage[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xparent   <= 1'b0;
      erase_en  <= 1'b0;
      busy_q    <= 1'b1;
      loading   <= 1'b0;
      iss_ptr   <= '0;
      fill_v    <= 1'b0;
      fill_ptr  <= '0;
      done_pend <= 1'b0;
    end else begin
      fill_v    <= nv_rd_en;
      fill_ptr  <= nv_addr;
      done_pend <= fill_v && (fill_ptr == AW'(NREG-1));
      if (nv_rd_en) iss_ptr <= iss_ptr + 1'b1;
      if (host_ok && ctl_wr) begin
        xparent  <= ctl_din[0];
        erase_en <= ctl_din[2];
      end
      if (busy_q && !loading && supply_ok) begin
        loading <= 1'b1;
        iss_ptr <= '0;
      end
      if (reload) begin
        busy_q  <= 1'b1;
        loading <= 1'b1;
        iss_ptr <= '0;
      end
      if (done_pend) begin
        busy_q  <= 1'b0;
        loading <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        stage[i]  <= '0;
        active[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (fill_v && (fill_ptr == AW'(i))) stage[i] <= nv_data;
        if (do_commit) active[i] <= stage[i];
      end
      if (host_ok && wr_en && addr_ok) begin
        stage[wr_addr] <= wr_data;
        if (xparent) active[wr_addr] <= wr_data;
      end
    end
  end

  // R3
  staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ok && wr_en && !xparent && !(ctl_wr && ctl_din[1])) |=> $stable(act_cfg));

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !wr_en) |=> (act_cfg == $past(stage_flat)));

  // R7
  nv_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_rd_en && $past(nv_rd_en)) |-> (nv_addr == $past(nv_addr) + 1'b1));

  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && busy_q) |-> $stable(act_cfg));

  // R10
  erase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_erase |-> ctl_q[1]);

  // R6
  no_early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_rd_en |-> busy_q);

endmodule

// File: tb/cfg_dbuf_bank_tb.sv
`timescale 1ns/1ps
module cfg_dbuf_bank_tb;
  localparam int N  = 16;
  localparam int W  = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0, supply_ok = 1'b0;
  logic            wr_en = 1'b0, ctl_wr = 1'b0, erase_req = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [W-1:0]    wr_data = '0;
  logic [3:0]      ctl_din = '0;
  logic [W-1:0]    nv_data = '0;
  logic            nv_rd_en, nv_erase, busy;
  logic [AW-1:0]   nv_addr;
  logic [1:0]      ctl_q;
  logic [N*W-1:0]  act_cfg;

  cfg_dbuf_bank #(.NREG(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_wr(ctl_wr), .ctl_din(ctl_din),
    .erase_req(erase_req), .nv_data(nv_data), .nv_rd_en(nv_rd_en),
    .nv_addr(nv_addr), .nv_erase(nv_erase), .busy(busy), .ctl_q(ctl_q),
    .act_cfg(act_cfg));

  logic [W-1:0] nv [N];
  always @(posedge clk) if (nv_rd_en) nv_data <= nv[nv_addr];

  logic [W-1:0] m_st [N];
  logic [W-1:0] m_act [N];
  logic [W-1:0] snap [N];
  logic m_busy, m_load, m_x, m_er, old_x;
  int   m_cnt;
  int   tests = 0, fails = 0;
  bit   done = 0;
  string phase = "R1";

  function automatic logic [N*W-1:0] flat_act();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = m_act[i];
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [N*W-1:0] a, logic [N*W-1:0] e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, a, e, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_st[i] = '0; m_act[i] = '0; end
      m_busy = 1; m_load = 0; m_x = 0; m_er = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_load) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_st = nv; m_act = nv; m_busy = 0; m_load = 0;
        end
      end else if (supply_ok) begin
        m_load = 1; m_cnt = N + 2;
      end
    end else begin
      snap = m_st; old_x = m_x;
      if (ctl_wr && ctl_din[1]) m_act = snap;
      if (wr_en) begin
        m_st[wr_addr] = wr_data;
        if (old_x) m_act[wr_addr] = wr_data;
      end
      if (ctl_wr) begin
        m_x = ctl_din[0]; m_er = ctl_din[2];
        if (ctl_din[3]) begin m_busy = 1; m_load = 1; m_cnt = N + 2; end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    if (!rst_n) begin
      check(act_cfg == '0 && busy && ctl_q == 2'b00, "R1 reset", act_cfg, '0);
    end else begin
      check(busy == m_busy, {phase, " busy"}, N*W'(busy), N*W'(m_busy));
      check(act_cfg == flat_act(), {phase, " active"}, act_cfg, flat_act());
      check(ctl_q == {m_er, m_x}, "R4 ctl_q", N*W'(ctl_q), N*W'({m_er, m_x}));
      check(nv_erase == (erase_req && m_er), "R10 erase", N*W'(nv_erase), N*W'(erase_req && m_er));
      check(nv_rd_en == (m_load && m_cnt > 2), "R7 rd_en", N*W'(nv_rd_en), N*W'(m_load && m_cnt > 2));
      if (m_load && m_cnt > 2)
        check(nv_addr == AW'(N + 2 - m_cnt), "R7 addr", N*W'(nv_addr), N*W'(N + 2 - m_cnt));
    end
  end

  task automatic drive(bit we, int a, int d, bit cw, int cd, bit er);
    @(posedge clk); #1;
    wr_en = we; wr_addr = AW'(a); wr_data = W'(d);
    ctl_wr = cw; ctl_din = 4'(cd); erase_req = er;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) nv[i] = W'(8'h31 + i * 13);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R6";  idle(4);
    phase = "R8";  drive(1, 2, 8'hEE, 1, 4'b0101, 0); drive(1, 3, 8'hDD, 0, 0, 0); idle(2);
    phase = "R7";  supply_ok = 1'b1; idle(N + 4);
    check(act_cfg == flat_act() && !busy, "R7 image loaded", act_cfg, flat_act());
    phase = "R3";  drive(1, 3, 8'hAA, 0, 0, 0); drive(1, 5, 8'h55, 0, 0, 0); idle(2);
    phase = "R4";  drive(0, 0, 0, 1, 4'b0010, 0); idle(2);
    phase = "R5";  drive(1, 7, 8'h77, 1, 4'b0010, 0); idle(1); drive(0, 0, 0, 1, 4'b0010, 0); idle(1);
    phase = "R2";  drive(0, 0, 0, 1, 4'b0001, 0); drive(1, 1, 8'h11, 0, 0, 0);
                   drive(1, 15, 8'hF0, 0, 0, 0); idle(1);
    phase = "R5";  drive(1, 9, 8'h99, 0, 0, 0); drive(1, 4, 8'h44, 0, 0, 0);
                   drive(1, 9, 8'h9A, 1, 4'b0011, 0); idle(2);
    phase = "R10"; drive(0, 0, 0, 0, 0, 1); drive(0, 0, 0, 1, 4'b0000, 1); drive(0, 0, 0, 0, 0, 1);
                   drive(0, 0, 0, 1, 4'b0100, 0); drive(0, 0, 0, 0, 0, 1); drive(0, 0, 0, 0, 0, 0);
                   drive(0, 0, 0, 0, 0, 1); idle(1);
    for (int i = 0; i < N; i += 3) nv[i] = W'(8'hC0 + i);
    phase = "R9";  drive(0, 0, 0, 1, 4'b1000, 0);
    phase = "R8";  drive(1, 6, 8'h66, 1, 4'b0011, 0); drive(1, 0, 8'h01, 0, 0, 0);
    phase = "R9";  idle(N + 4);
    check(act_cfg == flat_act() && !busy, "R9 image restored", act_cfg, flat_act());
    phase = "R3";  drive(1, 0, 8'h5A, 0, 0, 0); idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule